// File: doc/BRIEF.md
# Banked Address Translator with Switchable Maps

This block sits between an 8-bit CPU with a 16-bit address bus and a wider physical memory. It divides the 64KB logical space into eight 8KB slots and maps each slot to any 8KB physical block. The physical address is formed by placing the block number above the low 13 address bits. Four complete slot maps are held on chip. Software switches the whole memory map by changing one register field, and it can rewrite a map other than the one in use.

Two control bytes sit at the bottom of the logical space. The map control byte at `$0000` chooses the map used for translation, the map open for editing, and whether editing is allowed. The I/O control byte at `$0001` chooses one of six I/O pages and can turn the I/O window off. While the window is on, slot 6 (`$C000`-`$DFFF`) selects I/O instead of RAM. When editing is allowed, the eight slot entries of the edit map appear at `$0008`-`$000F`. The CPU can write them there and read them back.

Top module: `bank_mmu`

## Requirements
- R1: For an address in RAM, `phys_addr_o` equals the active map's entry for slot `addr_i[15:13]`, placed above `addr_i[12:0]`.
- R2: After reset, map 0 holds block n for slot n, maps 1 to 3 hold block 0 in every slot, both control bytes read 0, and the I/O window is on at page 0.
- R3: Control byte `$0000` holds the active map in bits 1:0, the edit map in bits 5:4 and edit enable in bit 7. A read returns those fields and zero in every other bit. A write takes effect at the next clock edge.
- R4: While edit is enabled, a write to `$0008+n` (n = 0..7) loads slot n of the edit map at the next clock edge. A read of that address returns the stored entry.
- R5: While edit is disabled, `$0008`-`$000F` are plain RAM: `reg_hit_o` is low, `ram_sel_o` is high, and writes there leave every map unchanged.
- R6: Writing the edit map does not change translation through a different active map.
- R7: Control byte `$0001` holds the I/O page in bits 2:0 and the window-off flag in bit 3. A read returns those bits and zero in bits 7:4.
- R8: While the window is on, any address in slot 6 gives `io_sel_o` high, `ram_sel_o` low, and `io_page_o` equal to the stored page.
- R9: A write to `$0001` whose page field is 6 or 7 leaves the stored page unchanged, but it still updates the window-off flag.
- R10: While the window is off, slot 6 goes to RAM through the active map like any other slot.
- R11: Addresses `$0000` and `$0001` always give `reg_hit_o` high, with neither RAM nor I/O selected. At most one of `ram_sel_o`, `io_sel_o` and `reg_hit_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU logical address |
| wdata_i | input | 8 | CPU write data |
| we_i | input | 1 | CPU write strobe |
| rdata_o | output | 8 | Register read data, valid while `reg_hit_o` is high |
| reg_hit_o | output | 1 | The address hits a translator register |
| phys_addr_o | output | 21 | Physical address (block number above the 13-bit offset) |
| ram_sel_o | output | 1 | The access goes to RAM |
| io_sel_o | output | 1 | The access goes to the I/O window |
| io_page_o | output | 3 | Selected I/O page |

## Verification
The hardest state to reach from the ports is a map open for editing that differs from the map used for translation. The bench has to show that writes land only in the edit map, and that writes made while editing is disabled land nowhere. The stimulus programs maps 1 to 3 through the entry window while map 0 stays active, and it checks translation in the same phase. It then switches each map in turn and sweeps every slot at two offsets. For the disabled-edit case it writes an entry address with editing off, then re-enables editing and reads that entry back through the same window.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int unsigned CPU_AW      = 16;
  localparam int unsigned OFFS_W      = 13;
  localparam int unsigned SLOT_W      = CPU_AW - OFFS_W;
  localparam int unsigned N_SLOTS     = 1 << SLOT_W;
  localparam int unsigned TBL_W       = 2;
  localparam int unsigned N_TABLES    = 1 << TBL_W;
  localparam int unsigned PAGE_W      = 3;
  localparam int unsigned N_IO_PAGES  = 6;
  localparam int unsigned IO_SLOT     = 6;
  localparam int unsigned BLOCK_W_DEF = 8;

  localparam logic [CPU_AW-1:0] MAP_CTRL_ADDR = 16'h0000;
  localparam logic [CPU_AW-1:0] IO_CTRL_ADDR  = 16'h0001;
  // entry window: $0008..$000F
  localparam logic [CPU_AW-SLOT_W-1:0] ENTRY_BASE = 13'd1;

  typedef struct packed {
    logic             edit_en;
    logic [TBL_W-1:0] edit_sel;
    logic [TBL_W-1:0] act_sel;
  } map_ctrl_t;

  typedef struct packed {
    logic              io_off;
    logic [PAGE_W-1:0] page;
  } io_ctrl_t;
endpackage

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output map_ctrl_t         map_ctrl_o,
  output io_ctrl_t          io_ctrl_o
);
  logic map_wr, io_wr, page_ok;

  assign map_wr  = we_i && (addr_i == MAP_CTRL_ADDR);
  assign io_wr   = we_i && (addr_i == IO_CTRL_ADDR);
  assign page_ok = (32'(wdata_i[PAGE_W-1:0]) < N_IO_PAGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_ctrl_o <= '0;
    end else if (map_wr) begin
      map_ctrl_o.edit_en  <= wdata_i[7];
      map_ctrl_o.edit_sel <= wdata_i[4 +: TBL_W];
      map_ctrl_o.act_sel  <= wdata_i[0 +: TBL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_ctrl_o <= '0;
    end else if (io_wr) begin
      io_ctrl_o.io_off <= wdata_i[PAGE_W];
      // out-of-range page values are dropped
      if (page_ok) io_ctrl_o.page <= wdata_i[PAGE_W-1:0];
    end
  end
endmodule

// File: rtl/mmu_tables.sv
module mmu_tables
  import mmu_pkg::*;
#(
  parameter int unsigned BLOCK_W = BLOCK_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [TBL_W-1:0]   edit_tbl_i,
  input  logic [SLOT_W-1:0]  edit_slot_i,
  input  logic [BLOCK_W-1:0] wr_data_i,
  input  logic [TBL_W-1:0]   act_tbl_i,
  input  logic [SLOT_W-1:0]  act_slot_i,
  output logic [BLOCK_W-1:0] act_blk_o,
  output logic [BLOCK_W-1:0] edit_blk_o
);
  logic [BLOCK_W-1:0] tbl_q [N_TABLES][N_SLOTS];

  for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      localparam logic [BLOCK_W-1:0] RST_VAL = (t == 0) ? BLOCK_W'(s) : '0;
      logic hit;
      assign hit = wr_en_i && (edit_tbl_i == TBL_W'(t)) && (edit_slot_i == SLOT_W'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  tbl_q[t][s] <= RST_VAL;
        else if (hit) tbl_q[t][s] <= wr_data_i;
      end
    end
  end

  assign act_blk_o  = tbl_q[act_tbl_i][act_slot_i];
  assign edit_blk_o = tbl_q[edit_tbl_i][edit_slot_i];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int unsigned BLOCK_W = BLOCK_W_DEF,
  localparam int unsigned PHYS_W = BLOCK_W + OFFS_W
) (
  input  logic [CPU_AW-1:0]  addr_i,
  input  map_ctrl_t          map_ctrl_i,
  input  io_ctrl_t           io_ctrl_i,
  input  logic [BLOCK_W-1:0] act_blk_i,
  input  logic [BLOCK_W-1:0] edit_blk_i,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               entry_hit_o,
  output logic [PHYS_W-1:0]  phys_addr_o,
  output logic               ram_sel_o,
  output logic               io_sel_o,
  output logic [PAGE_W-1:0]  io_page_o,
  output logic               reg_hit_o,
  output logic [7:0]         rdata_o
);
  logic map_hit, io_hit, in_window;

  assign slot_o      = addr_i[CPU_AW-1 -: SLOT_W];
  assign map_hit     = (addr_i == MAP_CTRL_ADDR);
  assign io_hit      = (addr_i == IO_CTRL_ADDR);
  assign in_window   = (addr_i[CPU_AW-1:SLOT_W] == ENTRY_BASE);
  assign entry_hit_o = in_window && map_ctrl_i.edit_en;

  assign reg_hit_o   = map_hit || io_hit || entry_hit_o;
  assign io_sel_o    = !io_ctrl_i.io_off && (slot_o == SLOT_W'(IO_SLOT));
  assign ram_sel_o   = !reg_hit_o && !io_sel_o;
  assign io_page_o   = io_ctrl_i.page;
  assign phys_addr_o = {act_blk_i, addr_i[OFFS_W-1:0]};

  always_comb begin
    rdata_o = '0;
    if (map_hit) begin
      rdata_o[7]           = map_ctrl_i.edit_en;
      rdata_o[4 +: TBL_W]  = map_ctrl_i.edit_sel;
      rdata_o[0 +: TBL_W]  = map_ctrl_i.act_sel;
    end else if (io_hit) begin
      rdata_o[PAGE_W:0]    = {io_ctrl_i.io_off, io_ctrl_i.page};
    end else if (entry_hit_o) begin
      rdata_o              = 8'(edit_blk_i);
    end
  end
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import mmu_pkg::*;
#(
  parameter int unsigned BLOCK_W = BLOCK_W_DEF,
  localparam int unsigned PHYS_W = BLOCK_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic              reg_hit_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              ram_sel_o,
  output logic              io_sel_o,
  output logic [2:0]        io_page_o
);
  map_ctrl_t          map_ctrl;
  io_ctrl_t           io_ctrl;
  logic [SLOT_W-1:0]  slot;
  logic               entry_hit;
  logic [BLOCK_W-1:0] act_blk, edit_blk;

  mmu_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .map_ctrl_o (map_ctrl),
    .io_ctrl_o  (io_ctrl)
  );

  mmu_tables #(.BLOCK_W(BLOCK_W)) u_tables (
    .clk_i, .rst_ni,
    .wr_en_i     (we_i && entry_hit),
    .edit_tbl_i  (map_ctrl.edit_sel),
    .edit_slot_i (addr_i[SLOT_W-1:0]),
    .wr_data_i   (wdata_i[BLOCK_W-1:0]),
    .act_tbl_i   (map_ctrl.act_sel),
    .act_slot_i  (slot),
    .act_blk_o   (act_blk),
    .edit_blk_o  (edit_blk)
  );

  mmu_xlate #(.BLOCK_W(BLOCK_W)) u_xlate (
    .addr_i,
    .map_ctrl_i  (map_ctrl),
    .io_ctrl_i   (io_ctrl),
    .act_blk_i   (act_blk),
    .edit_blk_i  (edit_blk),
    .slot_o      (slot),
    .entry_hit_o (entry_hit),
    .phys_addr_o,
    .ram_sel_o,
    .io_sel_o,
    .io_page_o,
    .reg_hit_o,
    .rdata_o
  );
endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk
  import mmu_pkg::*;
#(
  parameter int unsigned PHYS_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic [7:0]        wdata_i,
  input logic              we_i,
  input logic [7:0]        rdata_o,
  input logic              reg_hit_o,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic              ram_sel_o,
  input logic              io_sel_o,
  input logic [2:0]        io_page_o,
  input map_ctrl_t         map_ctrl,
  input io_ctrl_t          io_ctrl
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  a_r11_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, io_sel_o, reg_hit_o}));

  a_r11_ctrl_is_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:1] == 15'd0) |-> (reg_hit_o && !ram_sel_o && !io_sel_o));

  a_r8_io_in_slot6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_o |-> (addr_i[15:13] == 3'(IO_SLOT)) && !io_ctrl.io_off);

  a_r9_page_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(io_page_o) < N_IO_PAGES);

  a_r1_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |-> (phys_addr_o[12:0] == addr_i[12:0]));

  a_r3_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(we_i && addr_i == 16'h0000)) |->
      (map_ctrl.act_sel == $past(wdata_i[1:0]) && map_ctrl.edit_sel == $past(wdata_i[5:4])
       && map_ctrl.edit_en == $past(wdata_i[7])));

  a_r4_entry_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(we_i && map_ctrl.edit_en && addr_i[15:3] == 13'd1)
     && $stable(addr_i) && $stable(map_ctrl)) |-> (rdata_o == $past(wdata_i)));

  a_r5_locked_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(we_i && !map_ctrl.edit_en && addr_i[15:3] == 13'd1)
     && $stable(addr_i)) |-> $stable(phys_addr_o));
endmodule

bind bank_mmu bank_mmu_chk #(.PHYS_W(PHYS_W)) i_chk (
  .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o, .reg_hit_o,
  .phys_addr_o, .ram_sel_o, .io_sel_o, .io_page_o,
  .map_ctrl (map_ctrl),
  .io_ctrl  (io_ctrl)
);

// File: tb/test_bank_mmu.sv
`timescale 1ns/1ps
module test_bank_mmu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        reg_hit_o;
  logic [20:0] phys_addr_o;
  logic        ram_sel_o, io_sel_o;
  logic [2:0]  io_page_o;

  int errs = 0;
  int nchk = 0;
  logic [7:0] bm [4][8];

  always #5 clk_i = ~clk_i;

  bank_mmu i_bank_mmu (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [7:0] exp);
    addr_i = a; #1;
    chk({tag, " hit"}, 32'(reg_hit_o), 32'd1);
    chk({tag, " data"}, 32'(rdata_o), 32'(exp));
  endtask

  // expects RAM unless io_exp
  task automatic xl(string tag, logic [15:0] a, logic io_exp, logic [7:0] blk, logic [2:0] pg);
    addr_i = a; #1;
    chk({tag, " ram"}, 32'(ram_sel_o), 32'(!io_exp));
    chk({tag, " io"},  32'(io_sel_o), 32'(io_exp));
    if (io_exp) chk({tag, " page"}, 32'(io_page_o), 32'(pg));
    else        chk({tag, " phys"}, 32'(phys_addr_o), 32'({blk, a[12:0]}));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nchk++; errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [12:0] offs [2];
    offs[0] = 13'h0123; offs[1] = 13'h1FFF;
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 8; s++)
        bm[t][s] = (t == 0) ? 8'(s) : 8'h00;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: reset state
    rd("R2 map ctrl", 16'h0000, 8'h00);
    rd("R2 io ctrl", 16'h0001, 8'h00);
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < 2; o++)
        xl("R2 R1 R8 reset map", {3'(s), offs[o]}, s == 6, 8'(s), 3'd0);
    wr(16'h0000, 8'h01);
    xl("R2 map1 zero", 16'h6ABC, 1'b0, 8'h00, 3'd0);
    wr(16'h0000, 8'h00);

    // R4, R6: program maps 1..3 while map 0 stays active
    for (int t = 1; t < 4; t++) begin
      wr(16'h0000, 8'h80 | 8'(t << 4));
      for (int s = 0; s < 8; s++) begin
        bm[t][s] = 8'(t * 53 + s * 29 + 7);
        wr(16'h0008 + 16'(s), bm[t][s]);
        rd("R4 entry readback", 16'h0008 + 16'(s), bm[t][s]);
      end
      for (int s = 0; s < 8; s++)
        if (s != 6) xl("R6 active map untouched", {3'(s), offs[0]}, 1'b0, bm[0][s], 3'd0);
    end

    // R10, R1, R3: each map active, window off
    wr(16'h0001, 8'h08);
    rd("R7 io off readback", 16'h0001, 8'h08);
    for (int t = 0; t < 4; t++) begin
      wr(16'h0000, 8'(t) | 8'h30);
      rd("R3 map ctrl readback", 16'h0000, 8'(t) | 8'h30);
      for (int s = 0; s < 8; s++)
        for (int o = 0; o < 2; o++)
          xl("R1 R10 translate", {3'(s), offs[o]}, 1'b0, bm[t][s], 3'd0);
    end
    wr(16'h0000, 8'hFF);
    rd("R3 reserved bits zero", 16'h0000, 8'hB3);

    // R5: locked entry window
    wr(16'h0000, 8'h02);
    addr_i = 16'h000A; #1;
    chk("R5 no reg hit", 32'(reg_hit_o), 32'd0);
    chk("R5 ram sel", 32'(ram_sel_o), 32'd1);
    chk("R5 ram phys", 32'(phys_addr_o), 32'({bm[2][0], 13'h000A}));
    wr(16'h000A, 8'hAA);
    wr(16'h000F, 8'h55);
    addr_i = 16'h000A; #1;
    chk("R5 phys after write", 32'(phys_addr_o), 32'({bm[2][0], 13'h000A}));
    wr(16'h0000, 8'hA2);
    rd("R5 entry 2 kept", 16'h000A, bm[2][2]);
    rd("R5 entry 7 kept", 16'h000F, bm[2][7]);
    wr(16'h0000, 8'h00);

    // R7, R8: every page, window on
    for (int p = 0; p < 6; p++) begin
      wr(16'h0001, 8'(p));
      rd("R7 page readback", 16'h0001, 8'(p));
      xl("R8 io window lo", 16'hC000, 1'b1, 8'h00, 3'(p));
      xl("R8 io window hi", 16'hDFFF, 1'b1, 8'h00, 3'(p));
      xl("R8 slot7 ram", 16'hE010, 1'b0, bm[0][7], 3'd0);
    end

    // R9: out-of-range pages dropped
    wr(16'h0001, 8'h07);
    rd("R9 page 7 ignored", 16'h0001, 8'h05);
    wr(16'h0001, 8'h0E);
    rd("R9 off flag still set", 16'h0001, 8'h0D);
    xl("R9 R10 slot6 ram", 16'hC444, 1'b0, bm[0][6], 3'd0);
    wr(16'h0001, 8'hF3);
    rd("R7 upper bits zero", 16'h0001, 8'h03);

    // R11: control bytes are never RAM or I/O
    for (int a = 0; a < 2; a++) begin
      addr_i = 16'(a); #1;
      chk("R11 reg hit", 32'(reg_hit_o), 32'd1);
      chk("R11 no ram", 32'(ram_sel_o), 32'd0);
      chk("R11 no io", 32'(io_sel_o), 32'd0);
    end

    finish_run();
  end
endmodule